// File: doc/BRIEF.md
# Register-Started Stream-to-Memory DMA Channel

This block is one DMA channel that moves a block of bytes from an incoming data stream into a destination memory. Software programs a destination address and a byte count, then sets the start bit in the control register. The channel accepts 32-bit beats from the stream and writes each one to the next consecutive word address on a memory write port. Both sides use a valid/ready handshake.

Register values are trimmed as they are written. The destination is forced to 32-byte alignment inside a fixed window, with one region bit always set. The count is a multiple of 32 bytes. When the transfer ends, the control and count registers fall back to zero. The destination register moves forward by the bytes actually written, but only for the address region selected by bit 24. A one-cycle completion event is raised.

The source may end a transfer early by flagging its last beat. Register writes made while a transfer is in progress have no effect.

Top module: `stream_dma_chan`

## Requirements
- R1: A register write with select 0 stores (data AND 0x03FFFFE0) OR 0x10000000 as the destination; select 0 reads it back.
- R2: A register write with select 1 stores (data AND 0x00FFFFE0) as the byte count; select 1 reads it back. Select 3 reads zero and writes to it do nothing.
- R3: A write with select 2 keeps only data bit 0, and a 1 there starts a transfer. Writing 0 starts nothing. Reading select 2 returns the start bit in bit 0, a busy flag in bit 1, and zero elsewhere.
- R4: A transfer of N bytes issues N/4 memory writes. Beat k goes to destination+4k and carries the k-th stream beat unchanged, in order, under any stalling of either handshake.
- R5: When a transfer ends, the control register and the count register both read zero.
- R6: At the end of a transfer, if destination bit 24 is set, the destination register advances by the bytes written. Otherwise it keeps its value.
- R7: Every started transfer raises the completion output for exactly one clock cycle.
- R8: A stream beat with the end flag set is written and ends the transfer early. The destination advance (R6) then uses the bytes actually written.
- R9: Register writes of any select made while the busy flag is set leave all registers unchanged.
- R10: Starting with a count of zero completes with no memory writes, one completion pulse and the destination unchanged.
- R11: After reset all registers read zero, no memory write is valid, the stream is not accepted and the completion output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wsel | input | 2 | Register write select (0 dest, 1 count, 2 control) |
| reg_wdata | input | 32 | Register write data |
| reg_rsel | input | 2 | Register read select |
| reg_rdata | output | 32 | Register read data (combinational) |
| in_valid | input | 1 | Stream beat valid |
| in_ready | output | 1 | Stream beat accepted |
| in_data | input | 32 | Stream beat data |
| in_last | input | 1 | Stream end-of-data flag on the final beat |
| mem_valid | output | 1 | Memory write request valid |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | 32 | Memory write byte address |
| mem_data | output | 32 | Memory write data |
| xfer_done | output | 1 | One-cycle completion event |

## Verification
The sweep covers every count from zero to seven 32-byte blocks, with junk in the masked bits. Each count is tried with destinations both inside and outside the advancing region. This separates the address-advance rule from plain clearing and exposes off-by-one beat counts.

Each count is also run with the source ending after one beat, ending in mid-block, and running to completion. This tells the end-flag path apart from count exhaustion and checks that the advance follows the received amount.

Every case runs once with both handshakes always ready and once with independent stall patterns. Address/data pairing errors that free-flowing traffic would hide therefore show up. Register writes injected mid-transfer, and a start write with bit 0 clear, check that busy-time writes are ignored and that nothing starts without bit 0.

// File: rtl/stream_dma_pkg.sv
package stream_dma_pkg;

    typedef enum logic [1:0] {
        SEL_DEST = 2'd0,
        SEL_CNT  = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    localparam int CTRL_GO_BIT   = 0;
    localparam int CTRL_BUSY_BIT = 1;

endpackage

// File: rtl/stream_dma_regs.sv
module stream_dma_regs
    import stream_dma_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter logic [31:0] DEST_KEEP = 32'h03FF_FFE0,
    parameter logic [31:0] DEST_SET  = 32'h1000_0000,
    parameter logic [31:0] CNT_KEEP  = 32'h00FF_FFE0,
    parameter int          ADV_BIT   = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [ADDR_W-1:0] rd_data,
    input  logic              busy,
    input  logic              fin,
    input  logic [ADDR_W-1:0] moved,
    output logic [ADDR_W-1:0] dest_q,
    output logic [ADDR_W-1:0] count_q,
    output logic              start
);

    localparam logic [ADDR_W-1:0] KEEP_D = ADDR_W'(DEST_KEEP);
    localparam logic [ADDR_W-1:0] SET_D  = ADDR_W'(DEST_SET);
    localparam logic [ADDR_W-1:0] KEEP_C = ADDR_W'(CNT_KEEP);

    typedef struct packed {
        logic [ADDR_W-1:0] dest;
        logic [ADDR_W-1:0] count;
        logic              go;
    } regs_t;

    regs_t r_q, r_d;
    logic  wr_ok;

    always_comb begin
        r_d   = r_q;
        start = 1'b0;
        wr_ok = wr_en && !busy;
        if (fin) begin
            r_d.go    = 1'b0;
            r_d.count = '0;
            if (r_q.dest[ADV_BIT]) begin
                r_d.dest = r_q.dest + moved;
            end
        end else if (wr_ok) begin
            unique case (reg_sel_e'(wr_sel))
                SEL_DEST: r_d.dest  = (wr_data & KEEP_D) | SET_D;
                SEL_CNT:  r_d.count = wr_data & KEEP_C;
                SEL_CTRL: begin
                    r_d.go = wr_data[CTRL_GO_BIT];
                    start  = wr_data[CTRL_GO_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (reg_sel_e'(rd_sel))
            SEL_DEST: rd_data = r_q.dest;
            SEL_CNT:  rd_data = r_q.count;
            SEL_CTRL: begin
                rd_data[CTRL_GO_BIT]   = r_q.go;
                rd_data[CTRL_BUSY_BIT] = busy;
            end
            default: rd_data = '0;
        endcase
    end

    assign dest_q  = r_q.dest;
    assign count_q = r_q.count;

    AST_FIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> (count_q == '0) && !r_q.go); // R5

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fin) |=> ($stable(dest_q) && $stable(count_q))); // R9

    AST_CNT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q & ~KEEP_C) == '0); // R2

    AST_DEST_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && (wr_sel == SEL_DEST)) |=> ((dest_q & SET_D) == SET_D)); // R1

endmodule

// File: rtl/stream_dma_seq.sv
module stream_dma_seq
    import stream_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] dest,
    input  logic [ADDR_W-1:0] count,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_last,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [ADDR_W-1:0] m_addr,
    output logic [DATA_W-1:0] m_data,
    output logic              busy,
    output logic              fin,
    output logic [ADDR_W-1:0] moved
);

    localparam int                BEAT_BYTES = DATA_W / 8;
    localparam logic [ADDR_W-1:0] BEAT_INC   = ADDR_W'(BEAT_BYTES);

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] remain;
        logic [ADDR_W-1:0] done_bytes;
    } seq_t;

    seq_t s_q, s_d;
    logic running;
    logic beat;

    always_comb begin
        s_d     = s_q;
        running = (s_q.st == ST_RUN) && (s_q.remain != '0);
        m_valid = running && s_valid;
        s_ready = running && m_ready;
        beat    = running && s_valid && m_ready;
        m_addr  = dest + s_q.done_bytes;
        m_data  = s_data;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st         = ST_RUN;
                    s_d.remain     = count;
                    s_d.done_bytes = '0;
                end
            end
            ST_RUN: begin
                if (s_q.remain == '0) begin
                    s_d.st = ST_DONE;
                end else if (beat) begin
                    s_d.remain     = s_q.remain - BEAT_INC;
                    s_d.done_bytes = s_q.done_bytes + BEAT_INC;
                    if ((s_q.remain == BEAT_INC) || s_last) begin
                        s_d.st = ST_DONE;
                    end
                end
            end
            ST_DONE: s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, remain: '0, done_bytes: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy  = (s_q.st != ST_IDLE);
    assign fin   = (s_q.st == ST_DONE);
    assign moved = s_q.done_bytes;

    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !fin); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!m_valid && !s_ready)); // R11

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready) |=> (!m_valid || (m_addr == $past(m_addr) + BEAT_INC))); // R4

    AST_MOVED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (moved <= count)); // R8

endmodule

// File: rtl/stream_dma_chan.sv
module stream_dma_chan
    import stream_dma_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          DATA_W    = 32,
    parameter logic [31:0] DEST_KEEP = 32'h03FF_FFE0,
    parameter logic [31:0] DEST_SET  = 32'h1000_0000,
    parameter logic [31:0] CNT_KEEP  = 32'h00FF_FFE0,
    parameter int          ADV_BIT   = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_wsel,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic [1:0]        reg_rsel,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              xfer_done
);

    logic              busy;
    logic              fin;
    logic              start;
    logic [ADDR_W-1:0] moved;
    logic [ADDR_W-1:0] dest_q;
    logic [ADDR_W-1:0] count_q;

    stream_dma_regs #(
        .ADDR_W   (ADDR_W),
        .DEST_KEEP(DEST_KEEP),
        .DEST_SET (DEST_SET),
        .CNT_KEEP (CNT_KEEP),
        .ADV_BIT  (ADV_BIT)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr),
        .wr_sel (reg_wsel),
        .wr_data(reg_wdata),
        .rd_sel (reg_rsel),
        .rd_data(reg_rdata),
        .busy   (busy),
        .fin    (fin),
        .moved  (moved),
        .dest_q (dest_q),
        .count_q(count_q),
        .start  (start)
    );

    stream_dma_seq #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .dest   (dest_q),
        .count  (count_q),
        .s_valid(in_valid),
        .s_ready(in_ready),
        .s_data (in_data),
        .s_last (in_last),
        .m_valid(mem_valid),
        .m_ready(mem_ready),
        .m_addr (mem_addr),
        .m_data (mem_data),
        .busy   (busy),
        .fin    (fin),
        .moved  (moved)
    );

    assign xfer_done = fin;

    AST_START_NEEDS_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !busy && (reg_wsel == 2'd2) && !reg_wdata[0]) |=> !busy); // R3

endmodule

// File: tb/test_stream_dma_chan.sv
`timescale 1ns/1ps
module test_stream_dma_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_wsel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [1:0]  reg_rsel = 2'd0;
    logic [31:0] reg_rdata;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        in_last = 1'b0;
    logic        mem_valid;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_addr;
    logic [31:0] mem_data;
    logic        xfer_done;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    stream_dma_chan i_stream_dma_chan (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_wsel(reg_wsel), .reg_wdata(reg_wdata),
        .reg_rsel(reg_rsel), .reg_rdata(reg_rdata),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
        .xfer_done(xfer_done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_wsel = sel; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] sel, output logic [31:0] val);
        reg_rsel = sel;
        #1;
        val = reg_rdata;
    endtask

    function automatic logic [31:0] dest_mask(input logic [31:0] v);
        return (v & 32'h03FF_FFE0) | 32'h1000_0000;
    endfunction

    // One transfer: count in 32-byte blocks, short_at = 0 means no end flag
    task automatic run_xfer(input logic [31:0] dest_raw, input int blocks,
                            input int short_at, input bit stall, input bit poke);
        logic [31:0] dexp, cexp, rv;
        int total, expect_beats, beats, supplied, events, cyc;
        bit  seen;
        dexp  = dest_mask(dest_raw);
        cexp  = 32'(blocks * 32);
        total = blocks * 8;
        expect_beats = (short_at != 0 && short_at < total) ? short_at : total;
        wr_reg(2'd0, dest_raw);
        rd_reg(2'd0, rv); check("R1 dest mask", rv, dexp);
        wr_reg(2'd1, cexp | 32'hFF00_001F);
        rd_reg(2'd1, rv); check("R2 count mask", rv, cexp);
        wr_reg(2'd2, 32'hFFFF_FFF1);
        beats = 0; supplied = 0; events = 0; seen = 0;
        for (cyc = 0; cyc < 3000 && !seen; cyc++) begin
            in_valid  = stall ? ((cyc % 4) != 1) : 1'b1;
            mem_ready = stall ? ((cyc % 3) != 0) : 1'b1;
            in_data   = 32'hA000_0000 + 32'(supplied);
            in_last   = (short_at != 0) && (supplied == short_at - 1);
            if (poke && cyc == 2) begin
                reg_wr = 1'b1;
                reg_wsel = blocks[0] ? 2'd0 : 2'd1;
                reg_wdata = 32'h0000_0040;
            end else begin
                reg_wr = 1'b0;
            end
            reg_rsel = 2'd2;
            #1;
            if (poke && cyc == 2) check("R9 busy flag read", reg_rdata, 32'h3);
            if (mem_valid && mem_ready) begin
                check(short_at != 0 ? "R8 beat addr" : "R4 beat addr", mem_addr, dexp + 32'(4 * beats));
                check("R4 beat data", mem_data, 32'hA000_0000 + 32'(beats));
                beats++;
            end
            if (in_valid && in_ready) supplied++;
            if (xfer_done) begin
                events++;
                seen = 1;
            end
            @(negedge clk);
        end
        reg_wr = 1'b0; in_valid = 1'b0; mem_ready = 1'b1; in_last = 1'b0;
        for (int k = 0; k < 3; k++) begin
            #1;
            if (xfer_done) events++;
            if (mem_valid) beats++;
            @(negedge clk);
        end
        check(blocks == 0 ? "R10 beat count" : "R8 beat count", 32'(beats), 32'(expect_beats));
        check("R7 event count", 32'(events), 32'd1);
        rd_reg(2'd2, rv); check("R5 ctrl cleared", rv, 32'h0);
        rd_reg(2'd1, rv); check("R5 count cleared", rv, 32'h0);
        if (dexp[24]) dexp = dexp + 32'(expect_beats * 4);
        rd_reg(2'd0, rv); check("R6 dest after", rv, dexp);
    endtask

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_reg(2'd0, rv); check("R11 dest reset", rv, 32'h0);
        rd_reg(2'd1, rv); check("R11 count reset", rv, 32'h0);
        rd_reg(2'd2, rv); check("R11 ctrl reset", rv, 32'h0);
        check("R11 outputs idle", {29'd0, mem_valid, in_ready, xfer_done}, 32'h0);

        // R3: bit 0 clear starts nothing
        wr_reg(2'd1, 32'h0000_0040);
        wr_reg(2'd2, 32'hFFFF_FFFE);
        in_valid = 1'b1; mem_ready = 1'b1;
        repeat (3) begin
            #1;
            check("R3 no start", {30'd0, mem_valid, xfer_done}, 32'h0);
            @(negedge clk);
        end
        in_valid = 1'b0;
        rd_reg(2'd2, rv); check("R3 ctrl stays clear", rv, 32'h0);
        rd_reg(2'd3, rv); check("R2 unused select", rv, 32'h0);

        for (int blocks = 0; blocks < 8; blocks++) begin
            for (int region = 0; region < 2; region++) begin
                for (int sh = 0; sh < 3; sh++) begin
                    for (int st = 0; st < 2; st++) begin
                        int short_at;
                        int expb;
                        short_at = (sh == 0) ? 0 : (sh == 1) ? 1 : blocks * 4 + 3;
                        expb = (short_at != 0 && short_at < blocks * 8) ? short_at : blocks * 8;
                        run_xfer(region != 0 ? 32'h0100_8F7F : 32'hFC00_1234,
                                 blocks, short_at, st != 0, (expb >= 2) && (st == 0));
                    end
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule